// File: doc/BRIEF.md
# Configuration Access Engine

This block lets software perform one configuration read or write toward a downstream link at a time. Software fills a small register set with a transaction code, a 64-bit target address, write data and byte strobes, then writes a go bit. The engine presents the request on a valid/ready port. It waits for a single completion beat, records the completion code and any read data, and raises a done bit that software clears by writing one to it.

The sequencing is a three-state machine. IDLE waits for a go write. The IDLE-to-REQ transition fires when go is written with a legal code. IDLE stays in IDLE when go is written with an illegal code: the engine finishes at once with an unsupported-request result. REQ holds the request valid. The REQ-to-WAIT transition fires when the link raises ready. WAIT ignores further go writes. The WAIT-to-IDLE transition fires when a completion beat arrives, and that beat updates the result registers.

Register word indices, as seen on `reg_addr`:

| Index | Contents |
|---|---|
| 0 | transaction code in bits 3:0 |
| 1 | result: bit 0 is the non-posted flag, bits 9:7 are the completion code (read only) |
| 2 | address, low word |
| 3 | address, high word |
| 4 | write data |
| 5 | byte strobes in bits 3:0 |
| 6 | read data (read only) |
| 7 | go: writing bit 0 launches; reading bit 0 gives 1 while busy |
| 8 | done: bit 0, write 1 to clear |

Top module: `cfg_access_engine`

## Requirements
- R1: The code in bits 3:0 of word 0 selects the transaction: 0x8 is a type-0 read, 0x9 a type-1 read, 0xA a type-0 write, 0xB a type-1 write. It is forwarded on `req_kind`. Any other code issues no request and finishes at once with completion code 1 and the non-posted flag 0.
- R2: Writing 1 to bit 0 of word 7 while idle launches the transfer, and `req_valid` is high in the next cycle. Bit 0 of word 7 reads 1 while busy and 0 once the transfer has finished.
- R3: Every finish sets bit 0 of word 8. Writing 1 to that bit clears it. A finish in the same cycle as the clear takes priority.
- R4: Bits 9:7 of word 1 take the completion code: 0 OK, 1 unsupported request, 2 configuration retry, 4 completer abort. Bit 0 of word 1 is 1 after any legal request.
- R5: A completion with code 0 for a read loads `cpl_data` into word 6. Any non-zero code, or a rejected code, loads all ones into word 6. A code-0 write leaves word 6 unchanged.
- R6: `req_addr` is {word 3, word 2}. The low word carries the bus in bits 27:20, the device in 19:15, the function in 14:12 and the dword offset in 11:2, passed unchanged. `req_strb` is word 5 bits 3:0. Each byte of `req_wdata` is the matching byte of word 4 where its strobe is 1, and zero where it is 0.
- R7: While busy, a go write is ignored, and writes to words 0, 2, 3, 4 and 5 are ignored. The engine stays busy until a completion arrives.
- R8: `req_valid` stays high until `req_ready` is seen. A completion beat arriving when the engine is not waiting has no effect.
- R9: After reset, every register reads 0, the engine is idle and `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr_en | input | 1 | host register write strobe |
| reg_addr | input | 4 | register word index for read and write |
| reg_wdata | input | 32 | host write data |
| reg_rdata | output | 32 | register read data, combinational from `reg_addr` |
| req_valid | output | 1 | request valid toward the link |
| req_ready | input | 1 | link accepts the request |
| req_kind | output | 4 | transaction code |
| req_addr | output | 64 | target address |
| req_wdata | output | 32 | write data with unstrobed bytes zeroed |
| req_strb | output | 4 | byte strobes |
| cpl_valid | input | 1 | completion beat |
| cpl_status | input | 3 | completion code |
| cpl_data | input | 32 | completion read data |

## Verification
The bench holds ready low for several cycles to catch an engine that drops valid early, or that lets a go or address write land mid-transfer and change the request. It drives each non-zero completion code and checks both the code and the all-ones read data, which catches a design that copies stale payload. It also checks that a code-0 write leaves the read data untouched. It writes an illegal code, which a faulty design would send on the link or leave hanging busy. It sends a stray completion while idle, which a careless design would latch as a result and flag as done.

// File: rtl/cae_pkg.sv
package cae_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } cae_state_t;

    localparam int IDX_KIND  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_ALO   = 2;
    localparam int IDX_AHI   = 3;
    localparam int IDX_WDAT  = 4;
    localparam int IDX_STRB  = 5;
    localparam int IDX_RDAT  = 6;
    localparam int IDX_GO    = 7;
    localparam int IDX_DONE  = 8;

    localparam logic [2:0] CODE_OK = 3'd0;
    localparam logic [2:0] CODE_UR = 3'd1;
endpackage

// File: rtl/cae_fsm.sv
module cae_fsm
    import cae_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic kind_ok,
    input  logic req_ready,
    input  logic cpl_valid,
    output logic busy,
    output logic req_valid,
    output logic finish,
    output logic reject
);
    cae_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_req && kind_ok) state_d = ST_REQ;
            ST_REQ:  if (req_ready)         state_d = ST_WAIT;
            ST_WAIT: if (cpl_valid)         state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        req_valid = (state_q == ST_REQ);
        reject    = (state_q == ST_IDLE) && go_req && !kind_ok;
        finish    = reject || ((state_q == ST_WAIT) && cpl_valid);
    end

    assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);

    assert_launch_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go_req && kind_ok) |=> req_valid);

    assert_wait_until_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cpl_valid) |=> busy && !req_valid);
endmodule

// File: rtl/cae_regs.sv
module cae_regs
    import cae_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              busy,
    input  logic              finish,
    input  logic              reject,
    input  logic [2:0]        cpl_status,
    input  logic [DATA_W-1:0] cpl_data,
    output logic              go_req,
    output logic [3:0]        kind_q,
    output logic [DATA_W-1:0] alo_q,
    output logic [DATA_W-1:0] ahi_q,
    output logic [DATA_W-1:0] wdat_q,
    output logic [STRB_W-1:0] strb_q
);
    logic [DATA_W-1:0] rd_q;
    logic [2:0]        code_q;
    logic              np_q;
    logic              done_q;
    logic              open_wr;

    function automatic logic hit(input logic [REG_AW-1:0] a, input int idx);
        return a == REG_AW'(idx);
    endfunction

    assign open_wr = wr_en && !busy;
    assign go_req  = open_wr && hit(addr, IDX_GO) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0; alo_q <= '0; ahi_q <= '0; wdat_q <= '0; strb_q <= '0;
        end else if (open_wr) begin
            if (hit(addr, IDX_KIND)) kind_q <= wdata[3:0];
            if (hit(addr, IDX_ALO))  alo_q  <= wdata;
            if (hit(addr, IDX_AHI))  ahi_q  <= wdata;
            if (hit(addr, IDX_WDAT)) wdat_q <= wdata;
            if (hit(addr, IDX_STRB)) strb_q <= wdata[STRB_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0; code_q <= '0; np_q <= 1'b0; done_q <= 1'b0;
        end else begin
            if (finish) begin
                code_q <= reject ? CODE_UR : cpl_status;
                np_q   <= !reject;
                if (reject || cpl_status != CODE_OK) rd_q <= '1;
                else if (!kind_q[1])                 rd_q <= cpl_data;
            end
            if (finish)                                          done_q <= 1'b1;
            else if (wr_en && hit(addr, IDX_DONE) && wdata[0])   done_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_AW'(IDX_KIND): rdata[3:0] = kind_q;
            REG_AW'(IDX_STAT): begin rdata[9:7] = code_q; rdata[0] = np_q; end
            REG_AW'(IDX_ALO):  rdata = alo_q;
            REG_AW'(IDX_AHI):  rdata = ahi_q;
            REG_AW'(IDX_WDAT): rdata = wdat_q;
            REG_AW'(IDX_STRB): rdata[STRB_W-1:0] = strb_q;
            REG_AW'(IDX_RDAT): rdata = rd_q;
            REG_AW'(IDX_GO):   rdata[0] = busy;
            REG_AW'(IDX_DONE): rdata[0] = done_q;
            default:           rdata = '0;
        endcase
    end

    assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q);

    assert_err_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && (reject || cpl_status != CODE_OK)) |=> (rd_q == '1));

    assert_reject_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && reject) |=> (code_q == CODE_UR && !np_q));

    assert_busy_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(alo_q) && $stable(kind_q) && $stable(strb_q));

    assert_idle_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(rd_q) && $stable(code_q));
endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine
    import cae_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [3:0]          req_kind,
    output logic [2*DATA_W-1:0] req_addr,
    output logic [DATA_W-1:0]   req_wdata,
    output logic [STRB_W-1:0]   req_strb,
    input  logic                cpl_valid,
    input  logic [2:0]          cpl_status,
    input  logic [DATA_W-1:0]   cpl_data
);
    logic busy, finish, reject, go_req, kind_ok;
    logic [3:0]        kind_q;
    logic [DATA_W-1:0] alo_q, ahi_q, wdat_q;
    logic [STRB_W-1:0] strb_q;

    assign kind_ok = (kind_q[3:2] == 2'b10);

    cae_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .kind_ok(kind_ok),
        .req_ready(req_ready), .cpl_valid(cpl_valid), .busy(busy),
        .req_valid(req_valid), .finish(finish), .reject(reject)
    );

    cae_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .finish(finish),
        .reject(reject), .cpl_status(cpl_status), .cpl_data(cpl_data),
        .go_req(go_req), .kind_q(kind_q), .alo_q(alo_q), .ahi_q(ahi_q),
        .wdat_q(wdat_q), .strb_q(strb_q)
    );

    assign req_kind = kind_q;
    assign req_addr = {ahi_q, alo_q};
    assign req_strb = strb_q;

    for (genvar b = 0; b < STRB_W; b++) begin : g_merge
        assign req_wdata[8*b +: 8] = strb_q[b] ? wdat_q[8*b +: 8] : 8'h00;
    end

    assert_payload_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_addr) && $stable(req_wdata) && $stable(req_kind));

    assert_reject_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !busy) |=> !req_valid);
endmodule

// File: tb/tb_cfg_access_engine.sv
module tb_cfg_access_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_kind;
    logic [63:0] req_addr;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_strb(req_strb), .cpl_valid(cpl_valid),
        .cpl_status(cpl_status), .cpl_data(cpl_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic serve(input int dly, input logic [2:0] st, input logic [31:0] dat);
        int n = 0;
        while (!req_valid && n < 50) begin @(negedge clk); n++; end
        chk("R2 request seen", {63'd0, req_valid}, 64'd1);
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk("R8 valid held", {63'd0, req_valid}, 64'd1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R8 valid drops after ready", {63'd0, req_valid}, 64'd0);
        repeat (2) @(negedge clk);
        cpl_valid = 1'b1; cpl_status = st; cpl_data = dat;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_status = '0; cpl_data = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 9; a++) begin
            hr(4'(a), d);
            chk("R9 reset register", {32'd0, d}, 64'd0);
        end
        chk("R9 reset valid", {63'd0, req_valid}, 64'd0);
    endtask

    task automatic t_read_ok();
        logic [31:0] d;
        hw(4'd0, 32'h8);
        hw(4'd2, 32'h0032A040);
        hw(4'd3, 32'h1);
        hw(4'd5, 32'hF);
        hw(4'd7, 32'h1);
        chk("R2 valid next cycle", {63'd0, req_valid}, 64'd1);
        hr(4'd7, d); chk("R2 go reads busy", {32'd0, d}, 64'd1);
        chk("R1 kind type0 read", {60'd0, req_kind}, 64'h8);
        chk("R6 address", req_addr, 64'h00000001_0032A040);
        serve(3, 3'd0, 32'hCAFEF00D);
        hr(4'd7, d); chk("R2 go reads 0 at end", {32'd0, d}, 64'd0);
        hr(4'd6, d); chk("R5 read data loaded", {32'd0, d}, 64'hCAFEF00D);
        hr(4'd1, d); chk("R4 ok status np", {32'd0, d}, 64'h1);
        hr(4'd8, d); chk("R3 done set", {32'd0, d}, 64'd1);
        hw(4'd8, 32'h1);
        hr(4'd8, d); chk("R3 done cleared", {32'd0, d}, 64'd0);
    endtask

    task automatic t_write_merge();
        logic [31:0] d;
        hw(4'd0, 32'hB);
        hw(4'd4, 32'hAABBCCDD);
        hw(4'd5, 32'hC);
        hw(4'd7, 32'h1);
        chk("R1 kind type1 write", {60'd0, req_kind}, 64'hB);
        chk("R6 merged data upper", {32'd0, req_wdata}, 64'hAABB0000);
        chk("R6 strobe", {60'd0, req_strb}, 64'hC);
        serve(0, 3'd0, 32'h0);
        hr(4'd6, d); chk("R5 write keeps read data", {32'd0, d}, 64'hCAFEF00D);
        hw(4'd8, 32'h1);
        hw(4'd0, 32'hA);
        hw(4'd4, 32'h11223344);
        hw(4'd5, 32'h2);
        hw(4'd7, 32'h1);
        chk("R6 merged data byte1", {32'd0, req_wdata}, 64'h00003300);
        chk("R1 kind type0 write", {60'd0, req_kind}, 64'hA);
        serve(1, 3'd0, 32'h0);
        hw(4'd8, 32'h1);
    endtask

    task automatic t_error(input logic [2:0] st, input logic [31:0] exp_stat);
        logic [31:0] d;
        hw(4'd0, 32'h9);
        hw(4'd7, 32'h1);
        serve(1, st, 32'h5A5A5A5A);
        hr(4'd1, d); chk("R4 error code", {32'd0, d}, {32'd0, exp_stat});
        hr(4'd6, d); chk("R5 error read data ones", {32'd0, d}, 64'hFFFFFFFF);
        hr(4'd8, d); chk("R3 done on error", {32'd0, d}, 64'd1);
        hw(4'd8, 32'h1);
    endtask

    task automatic t_illegal();
        logic [31:0] d;
        hw(4'd6 - 4'd6, 32'h3);
        hw(4'd7, 32'h1);
        chk("R1 illegal issues nothing", {63'd0, req_valid}, 64'd0);
        hr(4'd7, d); chk("R1 illegal not busy", {32'd0, d}, 64'd0);
        hr(4'd1, d); chk("R1 illegal code 1 np 0", {32'd0, d}, 64'h80);
        hr(4'd6, d); chk("R5 illegal read data ones", {32'd0, d}, 64'hFFFFFFFF);
        hr(4'd8, d); chk("R3 illegal done", {32'd0, d}, 64'd1);
        hw(4'd8, 32'h1);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] d;
        hw(4'd0, 32'h8);
        hw(4'd2, 32'h00100000);
        hw(4'd7, 32'h1);
        hw(4'd2, 32'h00200000);
        hw(4'd0, 32'hA);
        hw(4'd7, 32'h1);
        chk("R7 address held while busy", req_addr, 64'h00000001_00100000);
        chk("R7 kind held while busy", {60'd0, req_kind}, 64'h8);
        serve(2, 3'd0, 32'h0BADC0DE);
        hr(4'd7, d); chk("R7 second go ignored", {32'd0, d}, 64'd0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7 no extra request", {63'd0, req_valid}, 64'd0);
        end
        hr(4'd2, d); chk("R7 address write dropped", {32'd0, d}, 64'h00100000);
        hw(4'd8, 32'h1);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_status = 3'd4; cpl_data = 32'h12345678;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_status = '0;
        hr(4'd6, d); chk("R8 stray completion ignored data", {32'd0, d}, 64'h0BADC0DE);
        hr(4'd8, d); chk("R8 stray completion no done", {32'd0, d}, 64'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_ok();
        t_write_merge();
        t_error(3'd1, 32'h81);
        t_error(3'd2, 32'h101);
        t_error(3'd4, 32'h201);
        t_illegal();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule